// File: doc/BRIEF.md
# Multicore Interrupt Distribution Unit

This block is a shared interrupt distributor for a small cluster of processors. A set of common interrupt lines is programmed and driven by software through two registers: a command register and a parameter register. Each command word names one common line and one operation. Configuration values and query results pass through the parameter register. Each line holds a target-CPU bitmask, a destination mode and a trigger mode. Once a line is raised and the unit is enabled, the line is routed to the private interrupt inputs of the selected processors.

Software sends a command in two steps. It first writes any needed value to the parameter register, then writes the command word. To query a line, software writes the query command and then reads the parameter register. The processors report, through a per-CPU, per-line acknowledge input, that they have taken an interrupt. A line stays recorded until software sends a clear command for it.

Top module: `irq_distributor`

## Requirements
- R1: After reset the unit is disabled, every `cpu_irq` bit is 0 and the parameter register reads as 0.
- R2: A write to address 0x2001 loads the full data word into the parameter register. A read strobe at 0x2001 returns that word on `rdata` in the same cycle. Any other read returns 0. A write to address 0x2000 is a command: the line index is in bits 15:8 and the opcode is in bits 7:0.
- R3: Opcode 0x04 copies the parameter register into the addressed line's mode. Bit 15 is the trigger (0 = level, 1 = pulse) and bits 7:0 are the destination mode. Opcode 0x08 returns the mode in the same layout. Opcode 0x09 copies the parameter's low NUM_CPUS bits into the line's target mask, and opcode 0x0A returns that mask.
- R4: Opcode 0x03 raises a line. Opcode 0x05 then returns 1 in bit 0 until opcode 0x02 clears the line. After the clear, the status query returns 0 and the line's outputs fall.
- R5: Opcode 0x00 disables the unit and opcode 0x01 enables it. While the unit is disabled, every output is 0 but raises are still recorded. A line raised while the unit is disabled is delivered after the unit is enabled.
- R6: Destination mode 3 delivers a raised line n to every CPU in its mask, one cycle after the raise. CPU c sees line n on `cpu_irq[c*NUM_LINES+n]`, which is its private interrupt input 16+n.
- R7: Destination mode 2 delivers the line only to the lowest-numbered CPU in the mask.
- R8: Destination mode 1 delivers each raise to one CPU. The first delivery after reset goes to the lowest CPU in the mask. Each later delivery goes to the next CPU in the mask above the previous recipient, wrapping around past the highest CPU.
- R9: A line with destination mode 0, or with an empty mask, is never delivered.
- R10: In level trigger mode the output stays high until the line is cleared. In pulse trigger mode the output is high for exactly one cycle for each delivery.
- R11: A pulse on `cpu_ack` marks that CPU as having taken the line. Opcode 0x06 returns the mask of recipients that have taken the line. Opcode 0x07 returns the mask of recipients that have not yet taken it.
- R12: A command whose line index is NUM_LINES or higher changes no state. A query with such an index returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid in the same cycle as `rd_en` |
| cpu_ack | input | NUM_CPUS*NUM_LINES | Take pulse; bit c*NUM_LINES+n means CPU c took line n |
| cpu_irq | output | NUM_CPUS*NUM_LINES | Private interrupt outputs; bit c*NUM_LINES+n drives CPU c input 16+n |

## Verification
A wrong internal state shows up on `cpu_irq` within one cycle of the command that should have changed it. A stale round-robin pointer sends the next raise of that line to the wrong CPU. A wrong stored mode or mask makes the next delivery reach the wrong set of CPUs. A lost enable keeps every output at zero. Acknowledge and pending state stays hidden until a query, which exposes it through the parameter register on the very next read. Out-of-range commands can alias onto a real line, so the bench reads back the lines such an alias would hit.

// File: rtl/idu_pkg.sv
package idu_pkg;
   localparam logic [7:0] OP_UNIT_OFF  = 8'h00;
   localparam logic [7:0] OP_UNIT_ON   = 8'h01;
   localparam logic [7:0] OP_DROP      = 8'h02;
   localparam logic [7:0] OP_RAISE     = 8'h03;
   localparam logic [7:0] OP_SET_MODE  = 8'h04;
   localparam logic [7:0] OP_GET_STAT  = 8'h05;
   localparam logic [7:0] OP_GET_TAKEN = 8'h06;
   localparam logic [7:0] OP_GET_WAIT  = 8'h07;
   localparam logic [7:0] OP_GET_MODE  = 8'h08;
   localparam logic [7:0] OP_SET_MASK  = 8'h09;
   localparam logic [7:0] OP_GET_MASK  = 8'h0A;

   localparam logic [7:0] DST_NONE  = 8'd0;
   localparam logic [7:0] DST_ROUND = 8'd1;
   localparam logic [7:0] DST_FIRST = 8'd2;
   localparam logic [7:0] DST_ALL   = 8'd3;

   localparam int TRIG_POS = 15;
endpackage

// File: rtl/idu_cmd_decode.sv
module idu_cmd_decode #(
   parameter int NUM_LINES = 16,
   parameter int ADDR_W    = 16,
   parameter logic [15:0] CMD_ADDR = 16'h2000,
   localparam int LW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [15:0]       cmd_word,
   output logic              cmd_hit,
   output logic [7:0]        op,
   output logic [LW-1:0]     line_idx,
   output logic              line_ok,
   output logic [NUM_LINES-1:0] line_sel
);
   logic [7:0] line_raw;

   assign op       = cmd_word[7:0];
   assign line_raw = cmd_word[15:8];
   assign cmd_hit  = wr_en && (addr == ADDR_W'(CMD_ADDR));
   assign line_ok  = (int'(line_raw) < NUM_LINES);
   assign line_idx = LW'(line_raw);

   for (genvar n = 0; n < NUM_LINES; n++) begin : g_sel
      assign line_sel[n] = cmd_hit && (int'(line_raw) == n);
   end
endmodule

// File: rtl/idu_pick.sv
module idu_pick
   import idu_pkg::*;
#(
   parameter int NUM_CPUS = 4,
   localparam int PW = $clog2(NUM_CPUS)
) (
   input  logic [NUM_CPUS-1:0] tmask,
   input  logic [PW-1:0]       ptr,
   input  logic [7:0]          dest,
   output logic [NUM_CPUS-1:0] recip,
   output logic [PW-1:0]       next_ptr
);
   always_comb begin
      logic found;
      int   idx;
      recip    = '0;
      next_ptr = ptr;
      found    = 1'b0;
      idx      = 0;
      case (dest)
         DST_ALL: recip = tmask;
         DST_FIRST: begin
            for (int i = NUM_CPUS - 1; i >= 0; i--) begin
               if (tmask[i]) recip = NUM_CPUS'(1) << i;
            end
         end
         DST_ROUND: begin
            for (int i = 0; i < NUM_CPUS; i++) begin
               idx = (int'(ptr) + i) % NUM_CPUS;
               if (!found && tmask[idx]) begin
                  found      = 1'b1;
                  recip[idx] = 1'b1;
                  next_ptr   = PW'((idx + 1) % NUM_CPUS);
               end
            end
         end
         default: recip = '0;
      endcase
   end
endmodule

// File: rtl/idu_line.sv
module idu_line
   import idu_pkg::*;
#(
   parameter int NUM_CPUS = 4,
   localparam int PW = $clog2(NUM_CPUS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                unit_en,
   input  logic                wr_mode,
   input  logic                wr_mask,
   input  logic [7:0]          dest_in,
   input  logic                trig_in,
   input  logic [NUM_CPUS-1:0] mask_in,
   input  logic                raise,
   input  logic                drop,
   input  logic [NUM_CPUS-1:0] ack,
   output logic [NUM_CPUS-1:0] irq,
   output logic                status_q,
   output logic [NUM_CPUS-1:0] recip_q,
   output logic [NUM_CPUS-1:0] taken_q,
   output logic [7:0]          dest_q,
   output logic                trig_q,
   output logic [NUM_CPUS-1:0] tmask_q
);
   logic                sent_q;
   logic [NUM_CPUS-1:0] pulse_q;
   logic [PW-1:0]       ptr_q;
   logic [NUM_CPUS-1:0] pick;
   logic [PW-1:0]       ptr_nxt;
   logic                fire;

   idu_pick #(.NUM_CPUS(NUM_CPUS)) u_pick (
      .tmask(tmask_q), .ptr(ptr_q), .dest(dest_q),
      .recip(pick), .next_ptr(ptr_nxt)
   );

   assign fire = unit_en && status_q && !sent_q && (pick != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= 1'b0;
         sent_q   <= 1'b0;
         recip_q  <= '0;
         taken_q  <= '0;
         pulse_q  <= '0;
         ptr_q    <= '0;
         dest_q   <= DST_NONE;
         trig_q   <= 1'b0;
         tmask_q  <= '0;
      end else begin
         if (wr_mode) begin
            dest_q <= dest_in;
            trig_q <= trig_in;
         end
         if (wr_mask) tmask_q <= mask_in;
         pulse_q <= '0;
         if (drop) begin
            status_q <= 1'b0;
            sent_q   <= 1'b0;
            recip_q  <= '0;
            taken_q  <= '0;
         end else begin
            if (raise) status_q <= 1'b1;
            if (fire) begin
               sent_q  <= 1'b1;
               recip_q <= pick;
               pulse_q <= pick;
               if (dest_q == DST_ROUND) ptr_q <= ptr_nxt;
            end
            taken_q <= taken_q | (ack & recip_q);
         end
      end
   end

   assign irq = !unit_en ? '0 : (trig_q ? pulse_q : recip_q);
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
   import idu_pkg::*;
#(
   parameter int NUM_CPUS  = 4,
   parameter int NUM_LINES = 16,
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 32,
   parameter logic [15:0] CMD_ADDR = 16'h2000,
   parameter logic [15:0] PRM_ADDR = 16'h2001,
   localparam int LW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
   localparam int VW = NUM_CPUS * NUM_LINES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [VW-1:0]     cpu_ack,
   output logic [VW-1:0]     cpu_irq
);
   if (NUM_CPUS < 2 || NUM_CPUS > 32) begin : g_bad_cpus
      $error("irq_distributor: NUM_CPUS must be 2..32");
   end
   if (NUM_LINES < 2 || NUM_LINES > 256) begin : g_bad_lines
      $error("irq_distributor: NUM_LINES must be 2..256");
   end
   if (DATA_W < 16 || DATA_W < NUM_CPUS) begin : g_bad_data
      $error("irq_distributor: DATA_W too narrow");
   end
   if (ADDR_W < 16) begin : g_bad_addr
      $error("irq_distributor: ADDR_W must be at least 16");
   end

   logic                 unit_en_q;
   logic [DATA_W-1:0]    param_q;
   logic                 cmd_hit, line_ok;
   logic [7:0]           op;
   logic [LW-1:0]        line_idx;
   logic [NUM_LINES-1:0] line_sel;
   logic                 prm_wr;

   logic [NUM_LINES-1:0]   status_all, trig_all;
   logic [VW-1:0]          recip_all, taken_all, mask_all, irq_all;
   logic [NUM_LINES*8-1:0] dest_all;
   logic [DATA_W-1:0]      q_val;

   idu_cmd_decode #(
      .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .CMD_ADDR(CMD_ADDR)
   ) u_dec (
      .wr_en(wr_en), .addr(addr), .cmd_word(wdata[15:0]),
      .cmd_hit(cmd_hit), .op(op), .line_idx(line_idx),
      .line_ok(line_ok), .line_sel(line_sel)
   );

   assign prm_wr = wr_en && (addr == ADDR_W'(PRM_ADDR));

   for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
      idu_line #(.NUM_CPUS(NUM_CPUS)) u_line (
         .clk(clk), .rst_n(rst_n), .unit_en(unit_en_q),
         .wr_mode(line_sel[n] && op == OP_SET_MODE),
         .wr_mask(line_sel[n] && op == OP_SET_MASK),
         .dest_in(param_q[7:0]), .trig_in(param_q[TRIG_POS]),
         .mask_in(param_q[NUM_CPUS-1:0]),
         .raise(line_sel[n] && op == OP_RAISE),
         .drop(line_sel[n] && op == OP_DROP),
         .ack(cpu_ack_line(n)),
         .irq(irq_all[n*NUM_CPUS +: NUM_CPUS]),
         .status_q(status_all[n]),
         .recip_q(recip_all[n*NUM_CPUS +: NUM_CPUS]),
         .taken_q(taken_all[n*NUM_CPUS +: NUM_CPUS]),
         .dest_q(dest_all[n*8 +: 8]),
         .trig_q(trig_all[n]),
         .tmask_q(mask_all[n*NUM_CPUS +: NUM_CPUS])
      );
      for (genvar c = 0; c < NUM_CPUS; c++) begin : g_map
         assign cpu_irq[c*NUM_LINES + n] = irq_all[n*NUM_CPUS + c];
      end
   end

   function automatic logic [NUM_CPUS-1:0] cpu_ack_line(input int n);
      for (int c = 0; c < NUM_CPUS; c++) cpu_ack_line[c] = cpu_ack[c*NUM_LINES + n];
   endfunction

   always_comb begin
      q_val = '0;
      if (line_ok) begin
         case (op)
            OP_GET_STAT:  q_val[0] = status_all[line_idx];
            OP_GET_TAKEN: q_val[NUM_CPUS-1:0] = taken_all[line_idx*NUM_CPUS +: NUM_CPUS];
            OP_GET_WAIT:  q_val[NUM_CPUS-1:0] = recip_all[line_idx*NUM_CPUS +: NUM_CPUS]
                                              & ~taken_all[line_idx*NUM_CPUS +: NUM_CPUS];
            OP_GET_MODE: begin
               q_val[7:0]      = dest_all[line_idx*8 +: 8];
               q_val[TRIG_POS] = trig_all[line_idx];
            end
            OP_GET_MASK:  q_val[NUM_CPUS-1:0] = mask_all[line_idx*NUM_CPUS +: NUM_CPUS];
            default:      q_val = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         unit_en_q <= 1'b0;
         param_q   <= '0;
      end else if (prm_wr) begin
         param_q <= wdata;
      end else if (cmd_hit) begin
         case (op)
            OP_UNIT_OFF: unit_en_q <= 1'b0;
            OP_UNIT_ON:  unit_en_q <= 1'b1;
            OP_GET_STAT, OP_GET_TAKEN, OP_GET_WAIT,
            OP_GET_MODE, OP_GET_MASK: param_q <= q_val;
            default: ;
         endcase
      end
   end

   assign rdata = (rd_en && addr == ADDR_W'(PRM_ADDR)) ? param_q : '0;
endmodule

// File: rtl/idu_checker.sv
module idu_checker #(
   parameter int NUM_CPUS  = 4,
   parameter int NUM_LINES = 16,
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 32,
   parameter logic [15:0] CMD_ADDR = 16'h2000,
   localparam int VW = NUM_CPUS * NUM_LINES
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   wr_en,
   input logic [ADDR_W-1:0]      addr,
   input logic [15:0]            cmd_word,
   input logic                   unit_en,
   input logic [DATA_W-1:0]      param_q,
   input logic [VW-1:0]          cpu_irq,
   input logic [NUM_LINES-1:0]   status_all,
   input logic [VW-1:0]          recip_all,
   input logic [NUM_LINES*8-1:0] dest_all
);
   logic is_cmd;
   assign is_cmd = wr_en && (addr == ADDR_W'(CMD_ADDR));

   // R5: a disabled unit drives no private interrupt
   p_quiet_when_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !unit_en |-> cpu_irq == '0);

   // R5: the enable opcode turns the unit on
   p_enable_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (is_cmd && cmd_word[7:0] == 8'h01) |=> unit_en);

   // R2: the parameter register only moves on a write strobe
   p_param_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(param_q));

   for (genvar n = 0; n < NUM_LINES; n++) begin : g_ln
      // R4: clearing a line removes its recorded status
      p_drop_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (is_cmd && cmd_word[7:0] == 8'h02 && int'(cmd_word[15:8]) == n)
         |=> !status_all[n]);

      // R7 / R8: single-recipient modes deliver to exactly one CPU
      p_single_recipient_r7: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(recip_all[n*NUM_CPUS +: NUM_CPUS]) == '0
          && recip_all[n*NUM_CPUS +: NUM_CPUS] != '0
          && ($past(dest_all[n*8 +: 8]) == 8'd1 || $past(dest_all[n*8 +: 8]) == 8'd2))
         |-> $onehot(recip_all[n*NUM_CPUS +: NUM_CPUS]));

      // R9: a disabled destination mode never starts a delivery
      p_off_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(recip_all[n*NUM_CPUS +: NUM_CPUS]) == '0 && $past(dest_all[n*8 +: 8]) == 8'd0)
         |-> recip_all[n*NUM_CPUS +: NUM_CPUS] == '0);
   end
endmodule

bind irq_distributor idu_checker #(
   .NUM_CPUS(NUM_CPUS), .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W),
   .DATA_W(DATA_W), .CMD_ADDR(CMD_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
   .cmd_word(wdata[15:0]), .unit_en(unit_en_q), .param_q(param_q),
   .cpu_irq(cpu_irq), .status_all(status_all), .recip_all(recip_all),
   .dest_all(dest_all)
);

// File: tb/tb_irq_distributor.sv
module tb_irq_distributor;
   localparam int NC = 4;
   localparam int NL = 16;
   localparam logic [15:0] CMDA = 16'h2000;
   localparam logic [15:0] PRMA = 16'h2001;

   // dest[15:8], mask[7:4], expected recipients[3:0]
   localparam logic [15:0] VECS [0:7] = '{
      16'h03BB, 16'h0344, 16'h02A2, 16'h0288,
      16'h0262, 16'h00F0, 16'h0300, 16'h0200
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0, rd_en = 1'b0;
   logic [15:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [NC*NL-1:0] cpu_ack = '0;
   logic [NC*NL-1:0] cpu_irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   irq_distributor dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .cpu_ack(cpu_ack), .cpu_irq(cpu_irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic wr(input logic [15:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic cmd(input logic [7:0] line, input logic [7:0] op);
      wr(CMDA, {16'h0, line, op});
   endtask

   task automatic rd_prm(output logic [31:0] v);
      @(negedge clk);
      rd_en = 1'b1; addr = PRMA;
      #1 v = rdata;
      rd_en = 1'b0;
   endtask

   task automatic query(input logic [7:0] line, input logic [7:0] op, output logic [31:0] v);
      cmd(line, op);
      rd_prm(v);
   endtask

   task automatic setup_line(input logic [7:0] line, input logic [31:0] mode, input logic [3:0] mask);
      wr(PRMA, mode);
      cmd(line, 8'h04);
      wr(PRMA, {28'h0, mask});
      cmd(line, 8'h09);
   endtask

   function automatic logic [3:0] outs(input int n);
      for (int c = 0; c < NC; c++) outs[c] = cpu_irq[c*NL + n];
   endfunction

   initial begin
      repeat (40000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) step();
      rst_n = 1'b1;
      step();

      // R1: reset state
      chk("R1 outputs", 32'(cpu_irq), 32'h0);
      rd_prm(v);
      chk("R1 param", v, 32'h0);

      // R2: parameter write and readback
      wr(PRMA, 32'hA5C3_1234);
      rd_prm(v);
      chk("R2 param readback", v, 32'hA5C3_1234);
      @(negedge clk); rd_en = 1'b1; addr = CMDA; #1 v = rdata; rd_en = 1'b0;
      chk("R2 cmd address reads zero", v, 32'h0);

      cmd(8'h00, 8'h01); // enable

      // R3: mode and mask readback
      setup_line(8'd2, 32'h0000_8003, 4'h9);
      query(8'd2, 8'h08, v);
      chk("R3 mode readback", v, 32'h0000_8003);
      query(8'd2, 8'h0A, v);
      chk("R3 mask readback", v, 32'h9);

      // R6 R7 R9: destination table on line 5, level trigger
      for (int i = 0; i < 8; i++) begin
         cmd(8'd5, 8'h02);
         setup_line(8'd5, {24'h0, VECS[i][15:8]}, VECS[i][7:4]);
         cmd(8'd5, 8'h03);
         step();
         chk($sformatf("R6/R7/R9 table entry %0d", i), 32'(outs(5)), 32'(VECS[i][3:0]));
      end
      cmd(8'd5, 8'h02);

      // R5: raise while disabled, deliver after enable
      cmd(8'h00, 8'h00);
      setup_line(8'd7, 32'h3, 4'hF);
      cmd(8'd7, 8'h03);
      step(); step();
      chk("R5 disabled quiet", 32'(cpu_irq), 32'h0);
      query(8'd7, 8'h05, v);
      chk("R5 raise recorded", v, 32'h1);
      cmd(8'h00, 8'h01);
      step();
      chk("R5 delivered after enable", 32'(outs(7)), 32'hF);

      // R4 R10: level holds until clear
      step(); step();
      chk("R10 level holds", 32'(outs(7)), 32'hF);
      cmd(8'd7, 8'h02);
      chk("R4 outputs fall on clear", 32'(outs(7)), 32'h0);
      query(8'd7, 8'h05, v);
      chk("R4 status cleared", v, 32'h0);

      // R8: round robin over CPUs 0, 2, 3
      setup_line(8'd3, 32'h1, 4'hD);
      begin
         logic [3:0] rr_exp [0:3] = '{4'h1, 4'h4, 4'h8, 4'h1};
         for (int k = 0; k < 4; k++) begin
            cmd(8'd3, 8'h02);
            cmd(8'd3, 8'h03);
            step();
            chk($sformatf("R8 round robin delivery %0d", k), 32'(outs(3)), 32'(rr_exp[k]));
         end
      end
      cmd(8'd3, 8'h02);

      // R10: pulse trigger is one cycle wide
      setup_line(8'd9, 32'h8003, 4'h3);
      cmd(8'd9, 8'h03);
      step();
      chk("R10 pulse high", 32'(outs(9)), 32'h3);
      step();
      chk("R10 pulse one cycle", 32'(outs(9)), 32'h0);
      query(8'd9, 8'h07, v);
      chk("R11 pending before take", v, 32'h3);

      // R11: CPU 1 takes line 9
      @(negedge clk); cpu_ack[1*NL + 9] = 1'b1;
      @(negedge clk); cpu_ack = '0;
      query(8'd9, 8'h06, v);
      chk("R11 taken mask", v, 32'h2);
      query(8'd9, 8'h07, v);
      chk("R11 pending mask", v, 32'h1);

      // R12: out-of-range line index
      wr(PRMA, 32'hF);
      cmd(8'd20, 8'h09);
      cmd(8'd20, 8'h03);
      step();
      chk("R12 no outputs", 32'(cpu_irq), 32'h0);
      query(8'd4, 8'h0A, v);
      chk("R12 no alias onto line 4", v, 32'h0);
      wr(PRMA, 32'hF);
      query(8'd20, 8'h0A, v);
      chk("R12 query reads zero", v, 32'h0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule